// File: doc/BRIEF.md
# Colour Filter Array Gain-Index Sequencer

This block tells the analog front end of an image sensor which gain and offset register set to use for each pixel. Software describes the colour mosaic as two line words, one for even and one for odd sensor lines. Each line word is a row of four 2-bit colour slots. A definition register gives the number of active slots per line. Each field value names one of four gain registers and one of four offset registers.

While the beginning-of-line strobe is high, the block walks through the slots of the active line word once per pixel clock. When the last programmed slot is reached it starts again from the first slot. On each rising edge of the strobe it changes to the other line word, so lines alternate between the two patterns. A synchronous frame-start input moves the sequence back so that the next line uses the even-line word. The pattern used by a line is captured when the strobe rises, so register writes during a line do not change that line.

Top module: `cfa_gain_seq`

## Requirements
- R1: Writes with `wr_en` high store `wr_data` at `wr_addr`: address 0 is the even-line word, address 1 the odd-line word, and address 2 the definition register. Only bits 3:0 are stored at address 2. Address 3 stores nothing. `rd_data` shows the stored value at `rd_addr` in the same cycle. It reads zero in bits 7:4 of address 2 and in all bits of address 3.
- R2: After reset, `gain_addr` is 0, `offset_addr` is 4 and `pix_valid` is 0. All three registers read 0, and the next line uses the even-line word.
- R3: Count the clock edges at which `bol` is sampled high as k = 0, 1, 2, …, starting at the edge where it rises. Pixel k uses slot p = k mod (count+1), which is bits [2p+1:2p] of the active line word. The field value appears on `gain_addr` one clock after that edge.
- R4: Definition bits 1:0 hold the even-line slot count minus one, and bits 3:2 hold the odd-line slot count minus one. So 0 repeats one slot and 3 repeats four slots.
- R5: Each rising edge of `bol` selects the other line word from the previous line, unless R10 applies.
- R6: `offset_addr` is always `gain_addr` plus 4.
- R7: `pix_valid` equals the value of `bol` sampled at the previous clock edge.
- R8: While `bol` is sampled low, `gain_addr` and `offset_addr` keep their last values.
- R9: The line word and count used for a line are the stored values at the clock edge where `bol` rises. Writes made later in that line take effect from the next rising edge.
- R10: If `frame_start` is sampled high, the next line uses the even-line word. If `frame_start` is high at the same edge where `bol` rises, that line itself uses the even-line word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| frame_start | input | 1 | Restart the line alternation at the even line |
| bol | input | 1 | Line-active strobe, high for every pixel of a line |
| pix_valid | output | 1 | Index outputs belong to a pixel of the current line |
| gain_addr | output | 3 | Gain register address, 0 to 3 |
| offset_addr | output | 3 | Offset register address, 4 to 7 |

## Verification
The assertions assume that `bol` is low when reset is released. With that assumption, the first rising edge the checker sees is the same first rising edge the sequencer detects. They make no assumption about the timing of `frame_start` or register writes relative to `bol`. The bench keeps `bol` low through every reset. It then drives whole lines, writes in the middle of a line, frame starts that coincide with a line start, and a long random stream in which strobe, writes and frame starts change freely.

// File: rtl/cfa_seq_pkg.sv
// Shared sizes and register address codes for the gain-index sequencer.
// Assumes a power-of-two number of colour slots per line word.
package cfa_seq_pkg;
    localparam int FIELD_W     = 2;                      // bits per colour slot
    localparam int FIELDS      = 4;                      // slots per line word
    localparam int CNT_W       = $clog2(FIELDS);         // slot-count width
    localparam int LINE_W      = FIELD_W * FIELDS;       // line word width
    localparam int DEF_W       = 2 * CNT_W;              // definition width
    localparam int REG_W       = 8;                      // bus data width
    localparam int RADDR_W     = 2;                      // bus address width
    localparam int GADDR_W     = FIELD_W + 1;            // gain/offset address width
    localparam int OFFSET_BASE = 1 << FIELD_W;           // first offset register

    typedef enum logic [RADDR_W-1:0] {
        REG_LINE_EVEN = 2'd0,
        REG_LINE_ODD  = 2'd1,
        REG_LINE_DEF  = 2'd2,
        REG_UNUSED    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cfa_cfg_regs.sv
// Staged configuration registers: two line words and a definition word.
// Writes land here at any time; the line controller samples them only at
// a line start. Assumes a single writer and synchronous active-low reset.
module cfa_cfg_regs
    import cfa_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [RADDR_W-1:0]  rd_addr,
    output logic [REG_W-1:0]    rd_data,
    output logic [LINE_W-1:0]   line_even,
    output logic [LINE_W-1:0]   line_odd,
    output logic [DEF_W-1:0]    line_def
);
    // Capture writes into the addressed staged register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_even <= '0;
            line_odd  <= '0;
            line_def  <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_LINE_EVEN: line_even <= wr_data[LINE_W-1:0];
                REG_LINE_ODD:  line_odd  <= wr_data[LINE_W-1:0];
                REG_LINE_DEF:  line_def  <= wr_data[DEF_W-1:0];
                default:       ;
            endcase
        end
    end

    // Return the addressed register, zero-extended.
    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_LINE_EVEN: rd_data = REG_W'(line_even);
            REG_LINE_ODD:  rd_data = REG_W'(line_odd);
            REG_LINE_DEF:  rd_data = REG_W'(line_def);
            default:       rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cfa_line_ctrl.sv
// Line controller: detects the line-start edge, picks the line word, copies
// the pattern for the line and steps the slot position once per pixel.
// Assumes bol stays high for the whole line and is low while reset is released.
module cfa_line_ctrl
    import cfa_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bol,
    input  logic                frame_start,
    input  logic [LINE_W-1:0]   line_even,
    input  logic [LINE_W-1:0]   line_odd,
    input  logic [DEF_W-1:0]    line_def,
    output logic [FIELD_W-1:0]  cur_idx,
    output logic [CNT_W-1:0]    pos,
    output logic [CNT_W-1:0]    act_cnt,
    output logic                next_line
);
    logic                bol_q;
    logic                rise;
    logic                sel_now;
    logic [LINE_W-1:0]   act_word_q;
    logic [LINE_W-1:0]   word_src;
    logic [CNT_W-1:0]    cnt_src;
    logic [CNT_W-1:0]    pos_src;
    logic [FIELD_W-1:0]  slots [FIELDS];

    // Find the line start and the line word and count that apply to this pixel.
    always_comb begin
        rise     = bol & ~bol_q;
        sel_now  = frame_start ? 1'b0 : next_line;
        word_src = act_word_q;
        cnt_src  = act_cnt;
        pos_src  = pos;
        if (rise) begin
            word_src = sel_now ? line_odd : line_even;
            cnt_src  = sel_now ? line_def[DEF_W-1:CNT_W] : line_def[CNT_W-1:0];
            pos_src  = '0;
        end
    end

    // Split the line word into its colour slots.
    for (genvar g = 0; g < FIELDS; g++) begin : g_slot
        assign slots[g] = word_src[g*FIELD_W +: FIELD_W];
    end

    assign cur_idx = slots[pos_src];

    // Keep the pattern for the line, the alternation state and the slot position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bol_q      <= 1'b0;
            act_word_q <= '0;
            act_cnt    <= '0;
            next_line  <= 1'b0;
            pos        <= '0;
        end else begin
            bol_q <= bol;
            if (rise) begin
                act_word_q <= word_src;
                act_cnt    <= cnt_src;
                next_line  <= ~sel_now;
            end else if (frame_start) begin
                next_line  <= 1'b0;
            end
            if (bol) begin
                pos <= (pos_src == cnt_src) ? '0 : pos_src + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cfa_out_stage.sv
// Output registers: gain address, paired offset address and pixel-valid.
// Assumes cur_idx is meaningful only while bol is high; holds otherwise.
module cfa_out_stage
    import cfa_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bol,
    input  logic [FIELD_W-1:0]  cur_idx,
    output logic                pix_valid,
    output logic [GADDR_W-1:0]  gain_addr,
    output logic [GADDR_W-1:0]  offset_addr
);
    // Register the index for each active pixel and hold it between lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid   <= 1'b0;
            gain_addr   <= '0;
            offset_addr <= GADDR_W'(OFFSET_BASE);
        end else begin
            pix_valid <= bol;
            if (bol) begin
                gain_addr   <= GADDR_W'(cur_idx);
                offset_addr <= GADDR_W'(cur_idx) + GADDR_W'(OFFSET_BASE);
            end
        end
    end
endmodule

// File: rtl/cfa_gain_seq.sv
// Top of the gain-index sequencer: staged registers, line controller and
// output stage. Assumes all inputs are synchronous to clk.
module cfa_gain_seq
    import cfa_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [RADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [RADDR_W-1:0]  rd_addr,
    output logic [REG_W-1:0]    rd_data,
    input  logic                frame_start,
    input  logic                bol,
    output logic                pix_valid,
    output logic [GADDR_W-1:0]  gain_addr,
    output logic [GADDR_W-1:0]  offset_addr
);
    logic [LINE_W-1:0]   line_even;
    logic [LINE_W-1:0]   line_odd;
    logic [DEF_W-1:0]    line_def;
    logic [FIELD_W-1:0]  cur_idx;
    logic [CNT_W-1:0]    pos;
    logic [CNT_W-1:0]    act_cnt;
    logic                next_line;

    cfa_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .line_even (line_even),
        .line_odd  (line_odd),
        .line_def  (line_def)
    );

    cfa_line_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bol         (bol),
        .frame_start (frame_start),
        .line_even   (line_even),
        .line_odd    (line_odd),
        .line_def    (line_def),
        .cur_idx     (cur_idx),
        .pos         (pos),
        .act_cnt     (act_cnt),
        .next_line   (next_line)
    );

    cfa_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .bol         (bol),
        .cur_idx     (cur_idx),
        .pix_valid   (pix_valid),
        .gain_addr   (gain_addr),
        .offset_addr (offset_addr)
    );
endmodule

// File: rtl/cfa_gain_seq_chk.sv
// Property checker for the gain-index sequencer, bound to the top module.
// Assumes bol is low when reset is released.
module cfa_gain_seq_chk
    import cfa_seq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bol,
    input logic                frame_start,
    input logic                pix_valid,
    input logic [GADDR_W-1:0]  gain_addr,
    input logic [GADDR_W-1:0]  offset_addr,
    input logic [CNT_W-1:0]    pos,
    input logic [CNT_W-1:0]    act_cnt,
    input logic                next_line
);
    a_r7_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
        bol |=> pix_valid);

    a_r7_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !bol |=> !pix_valid);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bol |=> ($stable(gain_addr) && $stable(offset_addr)));

    a_r6_offset_pair: assert property (@(posedge clk) disable iff (!rst_n)
        offset_addr == gain_addr + GADDR_W'(OFFSET_BASE));

    a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= act_cnt);

    a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bol) && !frame_start) |=> (next_line != $past(next_line)));

    a_r10_frame_even: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !$rose(bol)) |=> !next_line);

    a_r10_frame_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && $rose(bol)) |=> next_line);
endmodule

bind cfa_gain_seq cfa_gain_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bol         (bol),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .gain_addr   (gain_addr),
    .offset_addr (offset_addr),
    .pos         (pos),
    .act_cnt     (act_cnt),
    .next_line   (next_line)
);

// File: tb/cfa_gain_seq_bench.sv
`timescale 1ns/1ps
module cfa_gain_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       frame_start = 1'b0;
    logic       bol = 1'b0;
    logic       pix_valid;
    logic [2:0] gain_addr;
    logic [2:0] offset_addr;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string phase_tag = "R2";

    // behavioural reference state
    int m_l0, m_l1, m_def, m_next, m_pos, m_aw, m_ac, m_bolq, m_sel;
    int e_gain, e_valid;

    always #10 clk = ~clk;   // 50 MHz

    cfa_gain_seq u_cfa_gain_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_start(frame_start), .bol(bol), .pix_valid(pix_valid),
        .gain_addr(gain_addr), .offset_addr(offset_addr)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rd(int a);
        case (a)
            0: return m_l0;
            1: return m_l1;
            2: return m_def;
            default: return 0;
        endcase
    endfunction

    // Reference model: advances one pixel clock at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_l0 = 0; m_l1 = 0; m_def = 0; m_next = 0; m_pos = 0;
            m_aw = 0; m_ac = 0; m_bolq = 0; e_gain = 0; e_valid = 0;
        end else begin
            if (bol && !m_bolq) begin
                m_sel  = frame_start ? 0 : m_next;
                m_aw   = m_sel ? m_l1 : m_l0;
                m_ac   = m_sel ? ((m_def >> 2) & 3) : (m_def & 3);
                m_pos  = 0;
                m_next = 1 - m_sel;
            end else if (frame_start) begin
                m_next = 0;
            end
            if (bol) begin
                e_gain = (m_aw >> (2 * m_pos)) & 3;
                m_pos  = (m_pos == m_ac) ? 0 : m_pos + 1;
            end
            e_valid = bol ? 1 : 0;
            m_bolq  = bol ? 1 : 0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_l0 = wr_data;
                    2'd1: m_l1 = wr_data;
                    2'd2: m_def = wr_data & 15;
                    default: ;
                endcase
            end
        end
    end

    // Compare the registered outputs against the model on every cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({"R3 gain_addr, phase ", phase_tag}, gain_addr, e_gain);
            check({"R6 offset_addr, phase ", phase_tag}, offset_addr, e_gain + 4);
            check({"R7 pix_valid, phase ", phase_tag}, pix_valid, e_valid);
        end
    end

    task automatic write_reg(input int a, input int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_rd(string tag, input int a, input int exp);
        rd_addr = 2'(a);
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        bol = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_line(input int n);
        bol = 1'b1;
        repeat (n) @(negedge clk);
        bol = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check("R2 gain after reset", gain_addr, 0);
        check("R2 offset after reset", offset_addr, 4);
        check("R2 valid after reset", pix_valid, 0);
        for (int a = 0; a < 4; a++) check_rd("R2 register reset value", a, 0);

        // R1: register writes and readback
        phase_tag = "R1";
        write_reg(0, 8'h06);      // even slots: 2,1,0,0
        write_reg(1, 8'h7D);      // odd slots: 1,3,3,1
        write_reg(2, 8'hFD);      // even count 1 (two slots), odd count 3 (four slots)
        write_reg(3, 8'hAA);      // no register
        check_rd("R1 even line word", 0, 8'h06);
        check_rd("R1 odd line word", 1, 8'h7D);
        check_rd("R1 definition upper bits zero", 2, 8'h0D);
        check_rd("R1 unused address reads zero", 3, 0);

        // R3/R4: even line, two-slot repeat
        phase_tag = "R3";
        bol = 1'b1;
        @(negedge clk); check("R3 pixel 0 slot 0", gain_addr, 2);
        @(negedge clk); check("R3 pixel 1 slot 1", gain_addr, 1);
        @(negedge clk); check("R4 two-slot wrap", gain_addr, 2);
        repeat (3) @(negedge clk);
        bol = 1'b0;
        @(negedge clk); check("R7 valid low after line", pix_valid, 0);
        @(negedge clk); check("R8 gain held", gain_addr, 1);
        check("R8 offset held", offset_addr, 5);

        // R5: next line uses the odd word
        phase_tag = "R5";
        bol = 1'b1;
        @(negedge clk); check("R5 odd line slot 0", gain_addr, 1);
        @(negedge clk); check("R4 odd line slot 1", gain_addr, 3);
        repeat (6) @(negedge clk);
        idle(3);

        // R9: write during an even line takes effect on the following even line
        phase_tag = "R9";
        bol = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hFF;
        @(negedge clk); check("R9 line keeps pattern", gain_addr, 1);
        wr_en = 1'b0;
        @(negedge clk); check("R9 line keeps pattern wrap", gain_addr, 2);
        idle(2);
        run_line(4); idle(2);
        bol = 1'b1;
        @(negedge clk); check("R9 new word used next line", gain_addr, 3);
        repeat (3) @(negedge clk);
        idle(2);

        // R10: frame start while idle, then coincident with a line start
        phase_tag = "R10";
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        idle(1);
        bol = 1'b1;
        @(negedge clk); check("R10 even line after frame start", gain_addr, 3);
        repeat (2) @(negedge clk);
        idle(2);
        frame_start = 1'b1; bol = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        check("R10 coincident start uses even word", gain_addr, 3);
        repeat (2) @(negedge clk);
        idle(2);
        bol = 1'b1;
        @(negedge clk); check("R10 then odd word", gain_addr, 1);
        repeat (2) @(negedge clk);
        idle(2);

        // R4: single-slot even line, three-slot odd line
        phase_tag = "R4";
        write_reg(2, 8'h08);
        write_reg(0, 8'hF6);
        write_reg(1, 8'h27);      // slots 3,1,2,0
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        bol = 1'b1;
        @(negedge clk); check("R4 single slot pixel 0", gain_addr, 2);
        @(negedge clk); check("R4 single slot pixel 1", gain_addr, 2);
        @(negedge clk); check("R4 single slot pixel 2", gain_addr, 2);
        idle(2);
        bol = 1'b1;
        @(negedge clk); check("R4 three-slot pixel 0", gain_addr, 3);
        @(negedge clk); check("R4 three-slot pixel 1", gain_addr, 1);
        @(negedge clk); check("R4 three-slot pixel 2", gain_addr, 2);
        @(negedge clk); check("R4 three-slot wrap", gain_addr, 3);
        idle(2);

        // Random stream against the model
        phase_tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) bol = ~bol;
            frame_start = ($urandom_range(0, 39) == 0);
            wr_en   = ($urandom_range(0, 7) == 0);
            wr_addr = 2'($urandom_range(0, 3));
            wr_data = 8'($urandom);
            rd_addr = 2'($urandom_range(0, 3));
            #1;
            check("R1 random readback", rd_data, exp_rd(int'(rd_addr)));
            @(negedge clk);
        end
        wr_en = 1'b0; frame_start = 1'b0;
        idle(3);
        finish_run();
    end
endmodule